// File: doc/BRIEF.md
# Compact Shift and Rotate Unit

A purely combinational datapath slice that executes the short-form shift instructions. It takes a 64-bit register operand, a 6-bit operation field and a 6-bit shift count. It produces the value to write back to the register. A small decoder inside the unit turns the operation field into an operand width and an operation. The width is byte, halfword, word or long. The operation is logical left, logical right, rotate left or arithmetic right.

Rotate left sits in the encoding slot that a full-length instruction would give to arithmetic left shift. Narrow results land in the low bits of the register and are sign-extended across the rest. Short forms have no way to request a flag update. For that reason the unit carries the condition code bits straight through and never changes them. Register selection and instruction fetch belong to the surrounding pipeline.

The operation field is the two octal digits that follow the leading `3` of the short shift opcode. Bits [5:0] of the field correspond to those two digits.

Top module: `compact_shifter`

## Requirements
- R1: Legal field values (octal) decode as follows. 00, 04, 10 and 14 select long (64-bit). 20, 24, 30 and 34 select word (32-bit). 22, 26, 32 and 36 select halfword (16-bit). 23, 27, 33 and 37 select byte (8-bit). Field bits [3:2] give the operation: 00 logical left, 01 logical right, 10 rotate left, 11 arithmetic right. `legal_o` is 1 for exactly these sixteen values.
- R2: For any other field value, `legal_o` is 0 and `res_o` equals `src_i` unchanged.
- R3: Logical left shift moves bits up within the selected width and fills vacated low positions with zeros.
- R4: Logical right shift moves bits down within the selected width and fills vacated high positions of that width with zeros.
- R5: Arithmetic right shift fills vacated high positions with copies of bit (width-1) of the operand.
- R6: Rotate left works inside the selected width only. Bits leaving the top of the width re-enter at bit 0.
- R7: For byte, halfword and word, `res_o` bits above the width are copies of result bit (width-1).
- R8: Only the low log2(width) bits of `cnt_i` are used, so the count is taken modulo the width.
- R9: An effective count of zero returns the operand's low width bits unchanged, sign-extended to 64 bits.
- R10: `flags_o` equals `flags_i` for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| field_i | input | 6 | Operation field (two octal digits after the leading 3) |
| src_i | input | 64 | Register operand |
| cnt_i | input | 6 | Shift count |
| flags_i | input | 4 | Condition codes before the instruction |
| res_o | output | 64 | Writeback value |
| flags_o | output | 4 | Condition codes after the instruction (unchanged) |
| legal_o | output | 1 | Field is a legal shift encoding |

## Verification
The bench builds the unit with the default 64-bit register width and 4-bit flag vector. With these defaults all four lane widths are elaborated, and the long lane exercises the full 6-bit count. Counts at and above each narrow width therefore reach the modulo behaviour, and the sign of the narrow lanes reaches the upper 56, 48 and 32 bits.

// File: rtl/cshift_pkg.sv
package cshift_pkg;
  typedef enum logic [1:0] {SZ_LONG, SZ_WORD, SZ_HALF, SZ_BYTE} sz_e;
  typedef enum logic [1:0] {OP_LSL, OP_LSR, OP_ROL, OP_ASR} op_e;
endpackage

// File: rtl/cshift_decode.sv
module cshift_decode
  import cshift_pkg::*;
(
  input  logic [5:0] field_i,
  output sz_e        sz_o,
  output op_e        op_o,
  output logic       legal_o
);
  always_comb begin
    op_o    = op_e'(field_i[3:2]);
    sz_o    = SZ_LONG;
    legal_o = 1'b0;
    if (!field_i[5]) begin
      if (!field_i[4]) begin
        sz_o    = SZ_LONG;
        legal_o = (field_i[1:0] == 2'b00);
      end else begin
        unique case (field_i[1:0])
          2'b00: begin sz_o = SZ_WORD; legal_o = 1'b1; end
          2'b10: begin sz_o = SZ_HALF; legal_o = 1'b1; end
          2'b11: begin sz_o = SZ_BYTE; legal_o = 1'b1; end
          default: legal_o = 1'b0;
        endcase
      end
    end
  end

  // decoded op must follow bits [3:2] whenever legal
  always_comb begin
    if (legal_o) p_op_field_r1: assert (op_o == op_e'(field_i[3:2]));
  end
endmodule

// File: rtl/cshift_lane.sv
module cshift_lane
  import cshift_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LW   = 8,
  localparam int CW  = $clog2(LW)
) (
  input  logic [LW-1:0]   val_i,
  input  logic [CW-1:0]   amt_i,
  input  op_e             op_i,
  output logic [XLEN-1:0] res_o
);
  logic [LW-1:0]   narrow;
  logic [2*LW-1:0] dbl;

  always_comb begin
    dbl = {val_i, val_i} << amt_i;
    unique case (op_i)
      OP_LSL: narrow = val_i << amt_i;
      OP_LSR: narrow = val_i >> amt_i;
      OP_ROL: narrow = dbl[2*LW-1:LW];
      OP_ASR: narrow = LW'($signed(val_i) >>> amt_i);
      default: narrow = val_i;
    endcase
  end

  generate
    if (LW < XLEN) begin : g_ext
      assign res_o = {{(XLEN-LW){narrow[LW-1]}}, narrow};
    end else begin : g_full
      assign res_o = narrow;
    end
  endgenerate

  always_comb begin
    if (amt_i == '0) p_zero_count_r9: assert (narrow == val_i);
    if (op_i == OP_LSL && amt_i != '0) p_lsl_fill_r3: assert (narrow[0] == 1'b0);
    if (op_i == OP_LSR && amt_i != '0) p_lsr_fill_r4: assert (narrow[LW-1] == 1'b0);
    if (op_i == OP_ASR) p_asr_sign_r5: assert (narrow[LW-1] == val_i[LW-1]);
    if (op_i == OP_ROL) p_rol_bits_r6: assert ($countones(narrow) == $countones(val_i));
  end
endmodule

// File: rtl/compact_shifter.sv
module compact_shifter
  import cshift_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int FLAG_W = 4,
  localparam int CNT_W = $clog2(XLEN),
  localparam int NLANE = 4
) (
  input  logic [5:0]        field_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [XLEN-1:0]   res_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              legal_o
);
  sz_e sz;
  op_e op;
  logic [XLEN-1:0] lane_res [NLANE];

  cshift_decode u_dec (
    .field_i (field_i),
    .sz_o    (sz),
    .op_o    (op),
    .legal_o (legal_o)
  );

  // lane g handles width 8<<g: byte, half, word, long
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LWS = (8 << g) > XLEN ? XLEN : (8 << g);
    cshift_lane #(.XLEN(XLEN), .LW(LWS)) u_lane (
      .val_i (src_i[LWS-1:0]),
      .amt_i (cnt_i[$clog2(LWS)-1:0]),
      .op_i  (op),
      .res_o (lane_res[g])
    );
  end

  always_comb begin
    res_o = src_i;
    if (legal_o) begin
      unique case (sz)
        SZ_BYTE: res_o = lane_res[0];
        SZ_HALF: res_o = lane_res[1];
        SZ_WORD: res_o = lane_res[2];
        default: res_o = lane_res[3];
      endcase
    end
  end

  // short forms have no flag-update bit
  assign flags_o = flags_i;

  always_comb begin
    if (legal_o && sz == SZ_BYTE)
      p_byte_ext_r7: assert (res_o == XLEN'($signed(res_o[7:0])));
    if (legal_o && sz == SZ_HALF)
      p_half_ext_r7: assert (res_o == XLEN'($signed(res_o[15:0])));
    if (legal_o && sz == SZ_WORD)
      p_word_ext_r7: assert (res_o == XLEN'($signed(res_o[31:0])));
  end
endmodule

// File: tb/compact_shifter_bench.sv
module compact_shifter_bench;
  logic        clk = 1'b0;
  logic [5:0]  field;
  logic [63:0] src;
  logic [5:0]  cnt;
  logic [3:0]  flags_in;
  logic [63:0] res;
  logic [3:0]  flags_out;
  logic        legal;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  compact_shifter u_compact_shifter (
    .field_i (field), .src_i (src), .cnt_i (cnt), .flags_i (flags_in),
    .res_o (res), .flags_o (flags_out), .legal_o (legal)
  );

  function automatic logic [64:0] model(logic [5:0] f, logic [63:0] s, logic [5:0] c);
    int wb;
    int amt;
    logic [63:0] v;
    logic t;
    case (f)
      6'o00, 6'o04, 6'o10, 6'o14: wb = 64;
      6'o20, 6'o24, 6'o30, 6'o34: wb = 32;
      6'o22, 6'o26, 6'o32, 6'o36: wb = 16;
      6'o23, 6'o27, 6'o33, 6'o37: wb = 8;
      default: wb = 0;
    endcase
    if (wb == 0) return {1'b0, s};
    amt = int'(c) % wb;
    v = s;
    for (int k = 0; k < amt; k++) begin
      t = v[wb-1];
      case (f[3:2])
        2'b00, 2'b10: begin
          for (int b = wb - 1; b > 0; b--) v[b] = v[b-1];
          v[0] = (f[3:2] == 2'b10) ? t : 1'b0;
        end
        default: begin
          for (int b = 0; b < wb - 1; b++) v[b] = v[b+1];
          v[wb-1] = (f[3:2] == 2'b11) ? t : 1'b0;
        end
      endcase
    end
    for (int b = wb; b < 64; b++) v[b] = v[wb-1];
    return {1'b1, v};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run(string tag, logic [5:0] f, logic [63:0] s, logic [5:0] c);
    logic [64:0] e;
    @(posedge clk);
    field = f; src = s; cnt = c; flags_in = 4'($urandom);
    @(negedge clk);
    e = model(f, s, c);
    chk(tag, "legal", {63'd0, legal}, {63'd0, e[64]});
    chk(tag, "result", res, e[63:0]);
    chk("R10", "flags", {60'd0, flags_out}, {60'd0, flags_in});
  endtask

  initial begin
    logic [5:0] legal_set [16] = '{6'o00, 6'o04, 6'o10, 6'o14, 6'o20, 6'o24, 6'o30, 6'o34,
                                  6'o22, 6'o26, 6'o32, 6'o36, 6'o23, 6'o27, 6'o33, 6'o37};
    field = '0; src = '0; cnt = '0; flags_in = '0;
    @(negedge clk);
    chk("R1", "idle result", res, 64'd0);
    chk("R1", "idle legal", {63'd0, legal}, 64'd1);
    run("R1", 6'o33, 64'h81, 6'd1);
    run("R1", 6'o26, 64'h8000, 6'd3);
    run("R2", 6'o01, 64'hDEAD_BEEF_0123_4567, 6'd5);
    run("R2", 6'o21, 64'hFFFF_0000_1234_5678, 6'd9);
    run("R2", 6'o40, 64'h0123_4567_89AB_CDEF, 6'd1);
    run("R3", 6'o00, 64'hFFFF_FFFF_FFFF_FFFF, 6'd63);
    run("R3", 6'o23, 64'h0000_0000_0000_00C1, 6'd6);
    run("R4", 6'o24, 64'hFFFF_FFFF_8000_0000, 6'd31);
    run("R4", 6'o04, 64'h8000_0000_0000_0000, 6'd1);
    run("R5", 6'o37, 64'h0000_0000_0000_0080, 6'd7);
    run("R5", 6'o14, 64'h8000_0000_0000_0000, 6'd63);
    run("R5", 6'o34, 64'h0000_0000_4000_0000, 6'd4);
    run("R6", 6'o32, 64'h0000_0000_0000_8001, 6'd1);
    run("R6", 6'o10, 64'hF000_0000_0000_000F, 6'd4);
    run("R7", 6'o20, 64'h1234_5678_4000_0000, 6'd1);
    run("R7", 6'o36, 64'hAAAA_AAAA_AAAA_F000, 6'd2);
    run("R8", 6'o23, 64'h0000_0000_0000_0011, 6'd9);
    run("R8", 6'o22, 64'h0000_0000_0000_0001, 6'd47);
    run("R9", 6'o27, 64'hFFFF_FFFF_FFFF_FF7F, 6'd8);
    run("R9", 6'o00, 64'h0123_4567_89AB_CDEF, 6'd0);
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] f;
      f = ($urandom % 8 == 0) ? 6'($urandom) : legal_set[$urandom % 16];
      run("RND", f, {$urandom, $urandom}, 6'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule